// File: doc/BRIEF.md
# Dual-Port Split Page-Size Translation Buffer

This block translates virtual addresses to physical addresses for two independent requesters in the same clock cycle. Cached mappings sit in two fully associative sections. The small-page section holds 4 KiB mappings and compares virtual bits 31..12. The large-page section holds 2 MiB and 4 MiB mappings and compares bits 31..21 or bits 31..22, depending on a per-entry size bit. Each requester reads its own private copy of both sections. One fill port writes each new mapping into both copies in the same cycle, so the copies always agree.

A page walker, which lies outside this block, installs mappings through the fill port. Each section picks its victim with its own round-robin pointer. When page tables change, software either drops every mapping or drops only the mappings that cover one given virtual address. A lookup is presented for one cycle. The result appears on the next cycle with a valid strobe, and carries a hit flag, the physical address, the permission bits and a flag that marks a match in both sections.

Top module: `tlb_split`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses and no response strobe is raised until a lookup is made.
- R2: A lookup presented in cycle N produces its response, with rspVld high, in cycle N+1. A port that made no lookup keeps rspVld low.
- R3: Size code 0 (4 KiB) matches virtual bits 31..12, and the physical address is the stored frame bits 31..12 joined to virtual bits 11..0.
- R4: Size code 1 (2 MiB) matches virtual bits 31..21, and the physical address is fill-address bits 31..21 joined to virtual bits 20..0.
- R5: Size code 2 (4 MiB) matches virtual bits 31..22, and the physical address is fill-address bits 31..22 joined to virtual bits 21..0.
- R6: Both lookup ports translate independently in the same cycle and see every fill.
- R7: Each section replaces entries round-robin from slot 0 with its own pointer. A fill into one section leaves the other section's pointer unchanged.
- R8: Flush-all invalidates every entry. A fill in the same cycle is discarded and does not move a pointer.
- R9: Flush-by-address invalidates, in both sections, every entry whose page covers the given address, and keeps all other entries.
- R10: When a lookup matches in both sections, the large-page entry supplies the address and permissions, and rspMulti is raised.
- R11: A fill with size code 3 writes nothing and moves no pointer.
- R12: A miss returns rspHit, rspPa, rspPerm and rspMulti all zero.
- R13: A lookup in the same cycle as a fill sees the contents from before the fill. The new mapping is visible from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lkVld | input | 2 | Lookup request, one bit per port |
| lkVa | input | 2x32 | Virtual address per port |
| fillVld | input | 1 | Install a mapping |
| fillVa | input | 32 | Virtual address of the mapping |
| fillPa | input | 32 | Physical address of the mapping |
| fillSize | input | 2 | 0 = 4 KiB, 1 = 2 MiB, 2 = 4 MiB, 3 = ignored |
| fillPerm | input | 4 | Permission bits to store |
| flushAll | input | 1 | Invalidate everything |
| flushVld | input | 1 | Invalidate the entries covering flushVa |
| flushVa | input | 32 | Address for the selective flush |
| rspVld | output | 2 | Response strobe per port |
| rspHit | output | 2 | Translation found |
| rspPa | output | 2x32 | Physical address |
| rspPerm | output | 2x4 | Permission bits |
| rspMulti | output | 2 | Match in both sections |

## Verification
The bench targets these corner cases:

- **Page-size offsets.** It probes addresses just inside and just outside each page size. A design that masks the wrong number of bits would either hit on the neighbouring page or return a wrong offset.
- **Overlapping mappings.** It installs a small page inside a 2 MiB page. A design that let the small entry win, or that never flagged the double match, would show up here.
- **Selective flush.** It flushes an address that lies inside both overlapping pages. A design that cleared only one of the two, or that also cleared unrelated entries, would return stale hits or lose valid ones.
- **Replacement order.** It drives the replacement sequence through a large fill and through a reserved-size fill. The slot that gets evicted then shows whether a pointer moved when it should not have.
- **Same-cycle fill and lookup, flush and fill.** A lookup made during a fill must miss. A fill made during flush-all must be lost.

// File: rtl/tlb_split_pkg.sv
package tlb_split_pkg;
  typedef enum logic [1:0] {
    PG_4K   = 2'd0,
    PG_2M   = 2'd1,
    PG_4M   = 2'd2,
    PG_RSVD = 2'd3
  } pgSize_e;

  typedef struct packed {
    logic clearAll;
    logic clearAddr;
    logic wrSmall;
    logic wrLarge;
  } tlbStrobe_t;
endpackage

// File: rtl/tlb_split_ctrl.sv
module tlb_split_ctrl
  import tlb_split_pkg::*;
#(
  parameter int SMALL_N = 8,
  parameter int LARGE_N = 4,
  localparam int SIDX_W = $clog2(SMALL_N),
  localparam int LIDX_W = $clog2(LARGE_N)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fillVld,
  input  logic [1:0]        fillSize,
  input  logic              flushAll,
  input  logic              flushVld,
  output tlbStrobe_t        strb,
  output logic [SIDX_W-1:0] smallPtr,
  output logic [LIDX_W-1:0] largePtr
);
  logic fillOk;

  always_comb begin
    fillOk         = fillVld && !flushAll;
    strb.clearAll  = flushAll;
    strb.clearAddr = flushVld && !flushAll;
    strb.wrSmall   = fillOk && (fillSize == PG_4K);
    strb.wrLarge   = fillOk && ((fillSize == PG_2M) || (fillSize == PG_4M));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      smallPtr <= '0;
      largePtr <= '0;
    end else begin
      if (strb.wrSmall)
        smallPtr <= (smallPtr == SIDX_W'(SMALL_N - 1)) ? '0 : smallPtr + 1'b1;
      if (strb.wrLarge)
        largePtr <= (largePtr == LIDX_W'(LARGE_N - 1)) ? '0 : largePtr + 1'b1;
    end
  end

  AST_ONE_SECTION_WR: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.wrSmall && strb.wrLarge)); // R7
  AST_SMALL_PTR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrSmall |=> $stable(smallPtr)); // R7
  AST_LARGE_PTR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrLarge |=> $stable(largePtr)); // R11
endmodule

// File: rtl/tlb_split_dp.sv
module tlb_split_dp
  import tlb_split_pkg::*;
#(
  parameter int VA_W        = 32,
  parameter int PA_W        = 32,
  parameter int PERM_W      = 4,
  parameter int SMALL_N     = 8,
  parameter int LARGE_N     = 4,
  parameter int SMALL_SHIFT = 12,
  parameter int MID_SHIFT   = 21,
  parameter int BIG_SHIFT   = 22,
  localparam int NUM_PORTS  = 2,
  localparam int SIDX_W     = $clog2(SMALL_N),
  localparam int LIDX_W     = $clog2(LARGE_N)
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  tlbStrobe_t                          strb,
  input  logic [SIDX_W-1:0]                   smallPtr,
  input  logic [LIDX_W-1:0]                   largePtr,
  input  logic [VA_W-1:0]                     fillVa,
  input  logic [PA_W-1:0]                     fillPa,
  input  logic [1:0]                          fillSize,
  input  logic [PERM_W-1:0]                   fillPerm,
  input  logic [VA_W-1:0]                     flushVa,
  input  logic [NUM_PORTS-1:0]                lkVld,
  input  logic [NUM_PORTS-1:0][VA_W-1:0]      lkVa,
  output logic [NUM_PORTS-1:0]                rspVld,
  output logic [NUM_PORTS-1:0]                rspHit,
  output logic [NUM_PORTS-1:0][PA_W-1:0]      rspPa,
  output logic [NUM_PORTS-1:0][PERM_W-1:0]    rspPerm,
  output logic [NUM_PORTS-1:0]                rspMulti
);
  localparam int SVPN_W = VA_W - SMALL_SHIFT;
  localparam int SPFN_W = PA_W - SMALL_SHIFT;
  localparam int LVPN_W = VA_W - MID_SHIFT;
  localparam int LPFN_W = PA_W - MID_SHIFT;
  localparam int BIG_D  = BIG_SHIFT - MID_SHIFT;
  localparam logic [LVPN_W-1:0] BIG_MASK = {LVPN_W{1'b1}} << BIG_D;

  function automatic logic largeMatch(input logic [LVPN_W-1:0] vpn,
                                      input logic big,
                                      input logic [VA_W-1:0] addr);
    logic [LVPN_W-1:0] msk;
    msk = big ? BIG_MASK : {LVPN_W{1'b1}};
    return ((vpn ^ addr[VA_W-1:MID_SHIFT]) & msk) == '0;
  endfunction

  for (genvar cp = 0; cp < NUM_PORTS; cp++) begin : g_copy
    logic [SMALL_N-1:0] sValid, sNext, sFlush, sHit;
    logic [SVPN_W-1:0]  sVpn  [SMALL_N];
    logic [SPFN_W-1:0]  sPfn  [SMALL_N];
    logic [PERM_W-1:0]  sPerm [SMALL_N];
    logic [LARGE_N-1:0] lValid, lNext, lFlush, lHit, lBig;
    logic [LVPN_W-1:0]  lVpn  [LARGE_N];
    logic [LPFN_W-1:0]  lPfn  [LARGE_N];
    logic [PERM_W-1:0]  lPerm [LARGE_N];

    logic [VA_W-1:0]   va;
    logic [SIDX_W-1:0] sSel;
    logic [LIDX_W-1:0] lSel;
    logic              sAny, lAny;
    logic [PA_W-1:0]   pa;
    logic [PERM_W-1:0] perm;
    logic              vldQ, hitQ, multiQ;
    logic [PA_W-1:0]   paQ;
    logic [PERM_W-1:0] permQ;

    // flush-by-address coverage and next valid vector
    always_comb begin
      for (int i = 0; i < SMALL_N; i++)
        sFlush[i] = sVpn[i] == flushVa[VA_W-1:SMALL_SHIFT];
      for (int i = 0; i < LARGE_N; i++)
        lFlush[i] = largeMatch(lVpn[i], lBig[i], flushVa);
      sNext = sValid;
      lNext = lValid;
      if (strb.clearAddr) begin
        sNext = sNext & ~sFlush;
        lNext = lNext & ~lFlush;
      end
      if (strb.wrSmall) sNext[smallPtr] = 1'b1;
      if (strb.wrLarge) lNext[largePtr] = 1'b1;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        sValid <= '0;
        lValid <= '0;
      end else if (strb.clearAll) begin
        sValid <= '0;
        lValid <= '0;
      end else begin
        sValid <= sNext;
        lValid <= lNext;
      end
    end

    always_ff @(posedge clk) begin
      if (strb.wrSmall) begin
        sVpn[smallPtr]  <= fillVa[VA_W-1:SMALL_SHIFT];
        sPfn[smallPtr]  <= fillPa[PA_W-1:SMALL_SHIFT];
        sPerm[smallPtr] <= fillPerm;
      end
      if (strb.wrLarge) begin
        lVpn[largePtr]  <= fillVa[VA_W-1:MID_SHIFT];
        lPfn[largePtr]  <= fillPa[PA_W-1:MID_SHIFT];
        lPerm[largePtr] <= fillPerm;
        lBig[largePtr]  <= (fillSize == PG_4M);
      end
    end

    // lookup on this port's private copy
    always_comb begin
      va = lkVa[cp];
      for (int i = 0; i < SMALL_N; i++)
        sHit[i] = sValid[i] && (sVpn[i] == va[VA_W-1:SMALL_SHIFT]);
      for (int i = 0; i < LARGE_N; i++)
        lHit[i] = lValid[i] && largeMatch(lVpn[i], lBig[i], va);
      sSel = '0;
      for (int i = SMALL_N - 1; i >= 0; i--)
        if (sHit[i]) sSel = SIDX_W'(i);
      lSel = '0;
      for (int i = LARGE_N - 1; i >= 0; i--)
        if (lHit[i]) lSel = LIDX_W'(i);
      sAny = |sHit;
      lAny = |lHit;
      pa   = '0;
      perm = '0;
      if (lAny) begin
        if (lBig[lSel])
          pa = {lPfn[lSel][LPFN_W-1:BIG_D], va[BIG_SHIFT-1:0]};
        else
          pa = {lPfn[lSel], va[MID_SHIFT-1:0]};
        perm = lPerm[lSel];
      end else if (sAny) begin
        pa   = {sPfn[sSel], va[SMALL_SHIFT-1:0]};
        perm = sPerm[sSel];
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        vldQ   <= 1'b0;
        hitQ   <= 1'b0;
        multiQ <= 1'b0;
        paQ    <= '0;
        permQ  <= '0;
      end else begin
        vldQ   <= lkVld[cp];
        hitQ   <= lkVld[cp] && (sAny || lAny);
        multiQ <= lkVld[cp] && sAny && lAny;
        paQ    <= lkVld[cp] ? pa : '0;
        permQ  <= lkVld[cp] ? perm : '0;
      end
    end

    assign rspVld[cp]   = vldQ;
    assign rspHit[cp]   = hitQ;
    assign rspMulti[cp] = multiQ;
    assign rspPa[cp]    = paQ;
    assign rspPerm[cp]  = permQ;

    AST_CLEARALL_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
      strb.clearAll |=> (sValid == '0 && lValid == '0)); // R8
    AST_FILL_SETS_SLOT: assert property (@(posedge clk) disable iff (!rstN)
      strb.wrSmall |=> sValid[$past(smallPtr)]); // R7
    AST_MULTI_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rstN)
      rspMulti[cp] |-> rspHit[cp]); // R10
    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
      !rspHit[cp] |-> (rspPa[cp] == '0 && rspPerm[cp] == '0)); // R12
    AST_HIT_HAS_VLD: assert property (@(posedge clk) disable iff (!rstN)
      rspHit[cp] |-> rspVld[cp]); // R2
  end
endmodule

// File: rtl/tlb_split.sv
module tlb_split
  import tlb_split_pkg::*;
#(
  parameter int VA_W        = 32,
  parameter int PA_W        = 32,
  parameter int PERM_W      = 4,
  parameter int SMALL_N     = 8,
  parameter int LARGE_N     = 4,
  parameter int SMALL_SHIFT = 12,
  parameter int MID_SHIFT   = 21,
  parameter int BIG_SHIFT   = 22
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [1:0]                lkVld,
  input  logic [1:0][VA_W-1:0]      lkVa,
  input  logic                      fillVld,
  input  logic [VA_W-1:0]           fillVa,
  input  logic [PA_W-1:0]           fillPa,
  input  logic [1:0]                fillSize,
  input  logic [PERM_W-1:0]         fillPerm,
  input  logic                      flushAll,
  input  logic                      flushVld,
  input  logic [VA_W-1:0]           flushVa,
  output logic [1:0]                rspVld,
  output logic [1:0]                rspHit,
  output logic [1:0][PA_W-1:0]      rspPa,
  output logic [1:0][PERM_W-1:0]    rspPerm,
  output logic [1:0]                rspMulti
);
  localparam int SIDX_W = $clog2(SMALL_N);
  localparam int LIDX_W = $clog2(LARGE_N);

  tlbStrobe_t        strb;
  logic [SIDX_W-1:0] smallPtr;
  logic [LIDX_W-1:0] largePtr;

  tlb_split_ctrl #(.SMALL_N(SMALL_N), .LARGE_N(LARGE_N)) u_ctrl (
    .clk(clk), .rstN(rstN), .fillVld(fillVld), .fillSize(fillSize),
    .flushAll(flushAll), .flushVld(flushVld), .strb(strb),
    .smallPtr(smallPtr), .largePtr(largePtr)
  );

  tlb_split_dp #(
    .VA_W(VA_W), .PA_W(PA_W), .PERM_W(PERM_W), .SMALL_N(SMALL_N),
    .LARGE_N(LARGE_N), .SMALL_SHIFT(SMALL_SHIFT), .MID_SHIFT(MID_SHIFT),
    .BIG_SHIFT(BIG_SHIFT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .smallPtr(smallPtr),
    .largePtr(largePtr), .fillVa(fillVa), .fillPa(fillPa),
    .fillSize(fillSize), .fillPerm(fillPerm), .flushVa(flushVa),
    .lkVld(lkVld), .lkVa(lkVa), .rspVld(rspVld), .rspHit(rspHit),
    .rspPa(rspPa), .rspPerm(rspPerm), .rspMulti(rspMulti)
  );
endmodule

// File: tb/tlb_split_tb.sv
module tlb_split_tb;
  localparam int CLK_PERIOD = 10;

  logic             clk = 1'b0;
  logic             rstN;
  logic [1:0]       lkVld;
  logic [1:0][31:0] lkVa;
  logic             fillVld;
  logic [31:0]      fillVa, fillPa;
  logic [1:0]       fillSize;
  logic [3:0]       fillPerm;
  logic             flushAll, flushVld;
  logic [31:0]      flushVa;
  logic [1:0]       rspVld, rspHit, rspMulti;
  logic [1:0][31:0] rspPa;
  logic [1:0][3:0]  rspPerm;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  typedef struct {
    logic        hit;
    logic [31:0] pa;
    logic [3:0]  perm;
    logic        multi;
    string       tag;
  } exp_t;
  exp_t q0[$];
  exp_t q1[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  tlb_split u_dut (
    .clk(clk), .rstN(rstN), .lkVld(lkVld), .lkVa(lkVa), .fillVld(fillVld),
    .fillVa(fillVa), .fillPa(fillPa), .fillSize(fillSize), .fillPerm(fillPerm),
    .flushAll(flushAll), .flushVld(flushVld), .flushVa(flushVa),
    .rspVld(rspVld), .rspHit(rspHit), .rspPa(rspPa), .rspPerm(rspPerm),
    .rspMulti(rspMulti)
  );

  task automatic beginCycle();
    @(negedge clk);
    lkVld = '0; fillVld = 0; flushAll = 0; flushVld = 0;
  endtask

  task automatic look(int p, logic [31:0] va, logic hit, logic [31:0] pa,
                      logic [3:0] perm, logic multi, string tag);
    exp_t e;
    e.hit = hit; e.pa = hit ? pa : 32'h0; e.perm = hit ? perm : 4'h0;
    e.multi = multi; e.tag = tag;
    lkVld[p] = 1'b1;
    lkVa[p]  = va;
    if (p == 0) q0.push_back(e); else q1.push_back(e);
  endtask

  task automatic fill(logic [31:0] va, logic [31:0] pa, logic [1:0] sz, logic [3:0] perm);
    fillVld = 1; fillVa = va; fillPa = pa; fillSize = sz; fillPerm = perm;
  endtask

  task automatic checkPort(int p);
    exp_t e;
    checks++;
    if ((p == 0 && q0.size() == 0) || (p == 1 && q1.size() == 0)) begin
      failures++;
      $display("FAIL R2 port%0d unexpected response: actual rspVld=1 expected 0", p);
      return;
    end
    e = (p == 0) ? q0.pop_front() : q1.pop_front();
    if (rspHit[p] !== e.hit || rspPa[p] !== e.pa || rspPerm[p] !== e.perm ||
        rspMulti[p] !== e.multi) begin
      failures++;
      $display("FAIL %s port%0d actual hit=%0b pa=%h perm=%h multi=%0b expected hit=%0b pa=%h perm=%h multi=%0b",
               e.tag, p, rspHit[p], rspPa[p], rspPerm[p], rspMulti[p],
               e.hit, e.pa, e.perm, e.multi);
    end
  endtask

  // monitor: compare every response against the scoreboard
  always @(negedge clk) begin
    if (rstN === 1'b1) begin
      for (int p = 0; p < 2; p++)
        if (rspVld[p] === 1'b1) checkPort(p);
    end
  end

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired: actual running expected done");
    finish();
  end

  initial begin
    rstN = 0; lkVld = '0; lkVa = '0; fillVld = 0; fillVa = 0; fillPa = 0;
    fillSize = 0; fillPerm = 0; flushAll = 0; flushVld = 0; flushVa = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    checks++; // R1 reset state
    if (rspVld !== 2'b00 || rspHit !== 2'b00) begin
      failures++;
      $display("FAIL R1 after reset actual vld=%b hit=%b expected 00 00", rspVld, rspHit);
    end

    beginCycle(); // R1 R12 empty buffer misses
    look(0, 32'h1234_5678, 0, 0, 0, 0, "R1");
    look(1, 32'h0040_3000, 0, 0, 0, 0, "R12");

    beginCycle(); fill(32'h0040_3000, 32'h0ABC_D000, 2'd0, 4'h3);
    beginCycle(); // R3
    look(0, 32'h0040_3ABC, 1, 32'h0ABC_DABC, 4'h3, 0, "R3");
    look(1, 32'h0040_4000, 0, 0, 0, 0, "R3");

    beginCycle(); fill(32'h1040_0000, 32'h2060_0000, 2'd1, 4'h5);
    beginCycle(); // R4
    look(1, 32'h105F_FFF0, 1, 32'h207F_FFF0, 4'h5, 0, "R4");
    look(0, 32'h1060_0000, 0, 0, 0, 0, "R4");

    beginCycle(); fill(32'h4080_0000, 32'h8040_0000, 2'd2, 4'h9);
    beginCycle(); // R5
    look(0, 32'h40BF_0004, 1, 32'h807F_0004, 4'h9, 0, "R5");
    look(1, 32'h40C0_0000, 0, 0, 0, 0, "R5");

    beginCycle(); // R6 both ports at once
    look(0, 32'h0040_3010, 1, 32'h0ABC_D010, 4'h3, 0, "R6");
    look(1, 32'h1040_0008, 1, 32'h2060_0008, 4'h5, 0, "R6");

    beginCycle(); fill(32'h1041_2000, 32'h0000_5000, 2'd0, 4'h1);
    beginCycle(); // R10 overlap
    look(0, 32'h1041_2044, 1, 32'h2061_2044, 4'h5, 1, "R10");
    look(1, 32'h0040_3000, 1, 32'h0ABC_D000, 4'h3, 0, "R10");

    beginCycle(); flushVld = 1; flushVa = 32'h1041_2000;
    beginCycle(); // R9
    look(0, 32'h1041_2044, 0, 0, 0, 0, "R9");
    look(1, 32'h0040_3004, 1, 32'h0ABC_D004, 4'h3, 0, "R9");
    beginCycle();
    look(0, 32'h4080_0000, 1, 32'h8040_0000, 4'h9, 0, "R9");
    look(1, 32'h1050_0000, 0, 0, 0, 0, "R9");

    beginCycle(); flushAll = 1; fill(32'h0000_7000, 32'h0000_7000, 2'd0, 4'h2);
    beginCycle(); // R8
    look(0, 32'h0040_3000, 0, 0, 0, 0, "R8");
    look(1, 32'h4080_0000, 0, 0, 0, 0, "R8");
    beginCycle();
    look(0, 32'h0000_7000, 0, 0, 0, 0, "R8");

    beginCycle(); // R13 lookup during fill sees old state
    fill(32'h0000_9000, 32'h0001_1000, 2'd0, 4'h6);
    look(0, 32'h0000_9000, 0, 0, 0, 0, "R13");
    beginCycle();
    look(0, 32'h0000_9008, 1, 32'h0001_1008, 4'h6, 0, "R13");

    beginCycle(); // R2 idle port gives no strobe
    beginCycle();
    checks++;
    if (rspVld !== 2'b00) begin
      failures++;
      $display("FAIL R2 idle actual vld=%b expected 00", rspVld);
    end

    beginCycle(); fill(32'h0000_A000, 32'h0000_A000, 2'd3, 4'h1);
    beginCycle(); // R11
    look(0, 32'h0000_A000, 0, 0, 0, 0, "R11");
    look(1, 32'h0000_A000, 0, 0, 0, 0, "R11");

    // R7 small round robin, small pointer currently at slot 3
    for (int k = 0; k < 8; k++) begin
      beginCycle(); fill(32'h0010_0000 + k * 32'h1000, 32'h0020_0000 + k * 32'h1000, 2'd0, 4'(k));
      if (k == 3) begin
        beginCycle(); fill(32'hC000_0000, 32'h3000_0000, 2'd1, 4'h7);
      end
    end
    for (int j = 0; j < 4; j++) begin
      beginCycle();
      look(0, 32'h0010_0000 + (2*j) * 32'h1000, 1, 32'h0020_0000 + (2*j) * 32'h1000, 4'(2*j), 0, "R7");
      look(1, 32'h0010_0000 + (2*j+1) * 32'h1000, 1, 32'h0020_0000 + (2*j+1) * 32'h1000, 4'(2*j+1), 0, "R7");
    end
    beginCycle();
    look(0, 32'hC000_0100, 1, 32'h3000_0100, 4'h7, 0, "R7");
    beginCycle(); fill(32'h0010_8000, 32'h0020_8000, 2'd0, 4'h8);
    beginCycle(); // eviction hits the oldest small entry
    look(0, 32'h0010_0000, 0, 0, 0, 0, "R7");
    look(1, 32'h0010_1000, 1, 32'h0020_1000, 4'h1, 0, "R11");
    beginCycle();
    look(0, 32'h0010_8000, 1, 32'h0020_8000, 4'h8, 0, "R7");

    // R7 large round robin, large pointer at slot 3
    for (int k = 1; k <= 4; k++) begin
      beginCycle(); fill(32'hD000_0000 + k * 32'h20_0000, 32'h5000_0000 + k * 32'h20_0000, 2'd1, 4'hA);
    end
    beginCycle();
    look(0, 32'hC000_0100, 0, 0, 0, 0, "R7");
    look(1, 32'hD020_0010, 1, 32'h5020_0010, 4'hA, 0, "R7");
    beginCycle();
    look(0, 32'hD080_0000, 1, 32'h5080_0000, 4'hA, 0, "R7");

    beginCycle(); beginCycle(); beginCycle();
    checks++;
    if (q0.size() != 0 || q1.size() != 0) begin
      failures++;
      $display("FAIL R2 missing responses actual pending=%0d expected 0", q0.size() + q1.size());
    end
    finish();
  end
endmodule